// File: doc/BRIEF.md
# Floating-Point Status and Rounding Control Register

This block keeps the floating-point state that software and the arithmetic units share. The state is one 8-bit word. The accrued exception flags occupy bits [4:0] and the dynamic rounding mode occupies bits [7:5]. Software reaches this word through one of three views, chosen per request: the whole word, the flags alone, or the rounding mode alone.

Each accepted request applies one operation: swap, set bits, clear bits, or plain read. The block answers one cycle later with the value the selected view held before the request. This old value is zero-extended to the operand width. While software accesses the word, the execution units can OR newly raised exception flags into it in any cycle. Where a request writes a flag bit in that same cycle, the software value wins for that bit. The current flags and rounding mode are also driven out continuously.

A small response state machine has two states. RSP_IDLE moves to RSP_REPLY on an accepted request. RSP_REPLY stays in RSP_REPLY when another request arrives in the same cycle, and otherwise returns to RSP_IDLE. The response is valid exactly while the machine is in RSP_REPLY.

Top module: `fpu_status_ctl`

## Requirements
- R1: While reset is low, and after it, until the first request or raise, the exception flags and rounding mode read 0 and `rsp_valid` is 0.
- R2: A swap (op code 0) on the whole-word view (view code 0) stores operand bits [7:0] and drops all higher bits. The response is the previous whole word. For example, swapping 1 and then 0x1234 returns 1, after which the word is 0x34.
- R3: Any access to the flags view (view code 1) returns only word bits [4:0], zero-extended. With the word at 0x34, this returns 0x14.
- R4: A swap on the rounding-mode view (view code 2) writes operand bits [2:0] into word bits [7:5] and returns the old mode in bits [2:0] of the response. From word 0x34, swapping in 2 returns 1 and leaves the word at 0x54.
- R5: A clear (op code 2) zeroes the bits of the selected view that are 1 in the operand and returns the view's old value. From flags 0x14, clearing with 4 returns 0x14 and leaves the word at 0x50.
- R6: A set (op code 1) ORs the operand bits into the selected view and returns the view's old value. The set has no effect outside that view.
- R7: In every cycle, the 5-bit raise input is ORed into the flags. A raise never changes the rounding mode.
- R8: When a request writes a flag bit in the same cycle as a raise, the software value wins for that bit. The raise still applies to every flag bit the request does not write.
- R9: `rsp_valid` is 1 in exactly the cycle after each accepted request, including back-to-back requests. Response bits above 7 are always 0.
- R10: A read (op code 3) changes nothing and returns the view's value. A request to view code 3 changes nothing and returns 0.
- R11: `exc_flags_o` and `rnd_mode_o` always show the stored bits [4:0] and [7:5].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Software access request in this cycle |
| req_view | input | 2 | View select: 0 whole word, 1 flags, 2 rounding mode, 3 unused |
| req_op | input | 2 | Operation: 0 swap, 1 set, 2 clear, 3 read |
| req_operand | input | XLEN | Source operand, either an immediate or register data |
| exc_raise | input | 5 | Exception flags raised by the execution units this cycle |
| rsp_valid | output | 1 | Old-value response is valid |
| rsp_data | output | XLEN | Old value of the selected view, zero-extended |
| exc_flags_o | output | 5 | Current accrued exception flags |
| rnd_mode_o | output | 3 | Current dynamic rounding mode |

## Verification
The hardest case to reach is a software write and a unit raise landing on the same flag bits in the same cycle. Only that collision shows whether the write takes priority for its own bits while the raise still lands on the others. The stimulus drives a flags swap and a flags clear, each in the same cycle as a raise that overlaps some of the written bits and leaves others untouched. Back-to-back requests with no idle cycle between them exercise the response machine's self-loop in RSP_REPLY.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;

    localparam int EXC_W  = 5;
    localparam int RND_W  = 3;
    localparam int WORD_W = EXC_W + RND_W;

    typedef enum logic [1:0] {
        VIEW_WORD = 2'd0,
        VIEW_EXC  = 2'd1,
        VIEW_RND  = 2'd2,
        VIEW_NONE = 2'd3
    } view_e;

    typedef enum logic [1:0] {
        OP_SWAP  = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_READ  = 2'd3
    } op_e;

    typedef enum logic {
        RSP_IDLE  = 1'b0,
        RSP_REPLY = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/fpstat_access_decode.sv
module fpstat_access_decode
    import fpstat_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              req_valid,
    input  view_e             view,
    input  op_e               op,
    input  logic [XLEN-1:0]   operand,
    output logic [WORD_W-1:0] wr_mask,
    output logic [WORD_W-1:0] wr_val
);
    logic [WORD_W-1:0] span;
    logic [WORD_W-1:0] place;

    // Map the operand onto the word positions of the selected view.
    always_comb begin
        span  = '0;
        place = '0;
        unique case (view)
            VIEW_WORD: begin
                span  = '1;
                place = operand[WORD_W-1:0];
            end
            VIEW_EXC: begin
                span  = {{RND_W{1'b0}}, {EXC_W{1'b1}}};
                place = {{RND_W{1'b0}}, operand[EXC_W-1:0]};
            end
            VIEW_RND: begin
                span  = {{RND_W{1'b1}}, {EXC_W{1'b0}}};
                place = {operand[RND_W-1:0], {EXC_W{1'b0}}};
            end
            VIEW_NONE: begin
                span  = '0;
                place = '0;
            end
        endcase
    end

    // The operation decides which bits are written and with what value.
    always_comb begin
        wr_mask = '0;
        wr_val  = '0;
        if (req_valid) begin
            unique case (op)
                OP_SWAP: begin
                    wr_mask = span;
                    wr_val  = place;
                end
                OP_SET: begin
                    wr_mask = place;
                    wr_val  = '1;
                end
                OP_CLEAR: begin
                    wr_mask = place;
                    wr_val  = '0;
                end
                OP_READ: begin
                    wr_mask = '0;
                    wr_val  = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/fpstat_state_reg.sv
module fpstat_state_reg
    import fpstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] wr_mask,
    input  logic [WORD_W-1:0] wr_val,
    input  logic [EXC_W-1:0]  raise,
    output logic [WORD_W-1:0] word_q
);
    logic [WORD_W-1:0] raise_w;
    logic [WORD_W-1:0] word_d;

    assign raise_w = {{RND_W{1'b0}}, raise};

    // Per bit: a software-written bit takes the written value; any other bit keeps its value plus the raise.
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        assign word_d[b] = wr_mask[b] ? wr_val[b] : (word_q[b] | raise_w[b]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end
endmodule

// File: rtl/fpstat_view_mux.sv
module fpstat_view_mux
    import fpstat_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [WORD_W-1:0] word,
    input  view_e             view,
    output logic [XLEN-1:0]   view_val
);
    localparam int PAD_W = XLEN - WORD_W;

    always_comb begin
        unique case (view)
            VIEW_WORD: view_val = {{PAD_W{1'b0}}, word};
            VIEW_EXC:  view_val = {{(XLEN-EXC_W){1'b0}}, word[EXC_W-1:0]};
            VIEW_RND:  view_val = {{(XLEN-RND_W){1'b0}}, word[WORD_W-1:EXC_W]};
            VIEW_NONE: view_val = '0;
        endcase
    end
endmodule

// File: rtl/fpstat_resp_fsm.sv
module fpstat_resp_fsm
    import fpstat_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [XLEN-1:0] old_val,
    output logic            rsp_valid,
    output logic [XLEN-1:0] rsp_data
);
    rsp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_IDLE:  if (req_valid) state_d = RSP_REPLY;
            RSP_REPLY: state_d = req_valid ? RSP_REPLY : RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    // Capture the old value of the view as the request is accepted.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rsp_data <= '0;
        else if (req_valid) rsp_data <= old_val;
    end

    always_comb begin
        rsp_valid = (state_q == RSP_REPLY);
    end
endmodule

// File: rtl/fpu_status_ctl.sv
module fpu_status_ctl
    import fpstat_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_view,
    input  logic [1:0]      req_op,
    input  logic [XLEN-1:0] req_operand,
    input  logic [4:0]      exc_raise,
    output logic            rsp_valid,
    output logic [XLEN-1:0] rsp_data,
    output logic [4:0]      exc_flags_o,
    output logic [2:0]      rnd_mode_o
);
    view_e             view;
    op_e               op;
    logic [WORD_W-1:0] wr_mask;
    logic [WORD_W-1:0] wr_val;
    logic [WORD_W-1:0] word_q;
    logic [XLEN-1:0]   old_val;

    assign view = view_e'(req_view);
    assign op   = op_e'(req_op);

    fpstat_access_decode #(.XLEN(XLEN)) u_dec (
        .req_valid (req_valid),
        .view      (view),
        .op        (op),
        .operand   (req_operand),
        .wr_mask   (wr_mask),
        .wr_val    (wr_val)
    );

    fpstat_state_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (wr_mask),
        .wr_val  (wr_val),
        .raise   (exc_raise),
        .word_q  (word_q)
    );

    fpstat_view_mux #(.XLEN(XLEN)) u_mux (
        .word     (word_q),
        .view     (view),
        .view_val (old_val)
    );

    fpstat_resp_fsm #(.XLEN(XLEN)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .old_val   (old_val),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    assign exc_flags_o = word_q[EXC_W-1:0];
    assign rnd_mode_o  = word_q[WORD_W-1:EXC_W];
endmodule

// File: rtl/fpu_status_ctl_checker.sv
module fpu_status_ctl_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [1:0]      req_view,
    input logic [1:0]      req_op,
    input logic [XLEN-1:0] req_operand,
    input logic [4:0]      exc_raise,
    input logic            rsp_valid,
    input logic [XLEN-1:0] rsp_data,
    input logic [4:0]      exc_flags_o,
    input logic [2:0]      rnd_mode_o
);
    assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_rsp_without_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_rsp_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_data[XLEN-1:8] == '0));

    assert_raise_sticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ((exc_flags_o & $past(exc_raise)) == $past(exc_raise)));

    assert_idle_mode_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(rnd_mode_o));

    assert_read_keeps_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3) |=> $stable(rnd_mode_o));

    assert_swap_beats_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_view == 2'd1 && req_op == 2'd0) |=> (exc_flags_o == $past(req_operand[4:0])));
endmodule

bind fpu_status_ctl fpu_status_ctl_checker #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_view    (req_view),
    .req_op      (req_op),
    .req_operand (req_operand),
    .exc_raise   (exc_raise),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .exc_flags_o (exc_flags_o),
    .rnd_mode_o  (rnd_mode_o)
);

// File: tb/fpu_status_ctl_test.sv
module fpu_status_ctl_test;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [1:0]      req_view = '0;
    logic [1:0]      req_op = '0;
    logic [XLEN-1:0] req_operand = '0;
    logic [4:0]      exc_raise = '0;
    logic            rsp_valid;
    logic [XLEN-1:0] rsp_data;
    logic [4:0]      exc_flags_o;
    logic [2:0]      rnd_mode_o;

    always #5 clk = ~clk;

    fpu_status_ctl #(.XLEN(XLEN)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_view(req_view),
        .req_op(req_op), .req_operand(req_operand), .exc_raise(exc_raise),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .exc_flags_o(exc_flags_o), .rnd_mode_o(rnd_mode_o)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [XLEN-1:0] exp_q[$];
    string           tag_q[$];
    logic [7:0]      model = 8'h00;

    task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Driver: called at a negedge, drives one cycle, predicts from the requirements, returns at next negedge.
    task automatic drive(bit req, logic [1:0] view, logic [1:0] op,
                         logic [XLEN-1:0] operand, logic [4:0] raise, string tag);
        logic [7:0] span, place, wm, wv;
        logic [XLEN-1:0] oldv;
        req_valid   = req;
        req_view    = view;
        req_op      = op;
        req_operand = operand;
        exc_raise   = raise;
        case (view)
            2'd0: begin span = 8'hFF; place = operand[7:0];        oldv = {24'h0, model}; end
            2'd1: begin span = 8'h1F; place = {3'b0, operand[4:0]}; oldv = {27'h0, model[4:0]}; end
            2'd2: begin span = 8'hE0; place = {operand[2:0], 5'b0}; oldv = {29'h0, model[7:5]}; end
            default: begin span = 8'h00; place = 8'h00;             oldv = '0; end
        endcase
        wm = 8'h00; wv = 8'h00;
        if (req) begin
            case (op)
                2'd0: begin wm = span;  wv = place; end
                2'd1: begin wm = place; wv = 8'hFF; end
                2'd2: begin wm = place; wv = 8'h00; end
                default: begin wm = 8'h00; wv = 8'h00; end
            endcase
            exp_q.push_back(oldv);
            tag_q.push_back(tag);
        end
        model = (wv & wm) | ((model | {3'b0, raise}) & ~wm);
        @(negedge clk);
    endtask

    task automatic chk_state(string tag, logic [7:0] exp_word);
        chk({tag, " flags"}, {27'h0, exc_flags_o}, {27'h0, exp_word[4:0]});
        chk({tag, " mode"},  {29'h0, rnd_mode_o},  {29'h0, exp_word[7:5]});
    endtask

    // Monitor: pops the scoreboard when a response appears just after an edge.
    always begin
        @(posedge clk);
        #2;
        if (rst_n) begin
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R9: unexpected response actual 0x%0h expected none", rsp_data);
                end else begin
                    chk({"rsp ", tag_q.pop_front()}, rsp_data, exp_q.pop_front());
                end
            end else if (exp_q.size() != 0) begin
                checks++; fails++;
                $display("FAIL R9 %s: response missing actual 0 expected 1", tag_q.pop_front());
                void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset valid", {31'h0, rsp_valid}, '0);
        chk_state("R1 reset", 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk_state("R1 after release", 8'h00);

        // Whole word: swap returns previous value, truncates to 8 bits.
        drive(1, 2'd0, 2'd0, 32'h1, 5'h0, "R2 swap word 1");
        drive(1, 2'd0, 2'd0, 32'h1234, 5'h0, "R2 swap word 0x1234 old 1");
        chk_state("R2 R11 word 0x34", 8'h34);
        chk("R2 model 0x34", {24'h0, model}, 32'h34);
        drive(1, 2'd1, 2'd3, 32'h0, 5'h0, "R3 R10 read flags 0x14");
        drive(1, 2'd2, 2'd0, 32'h2, 5'h0, "R4 swap mode 2 old 1");
        drive(1, 2'd0, 2'd3, 32'hFF, 5'h0, "R4 word reads 0x54");
        chk_state("R4 word 0x54", 8'h54);
        drive(1, 2'd1, 2'd2, 32'h4, 5'h0, "R5 clear flag bit2 old 0x14");
        drive(1, 2'd0, 2'd3, 32'h0, 5'h0, "R5 word reads 0x50");
        chk_state("R5 word 0x50", 8'h50);
        drive(1, 2'd0, 2'd1, 32'h0F, 5'h0, "R6 set word 0x0F");
        drive(1, 2'd2, 2'd1, 32'h4, 5'h0, "R6 set mode bit2");
        chk_state("R6 word 0xDF", 8'hDF);
        drive(1, 2'd1, 2'd2, 32'hFFFF_FFFF, 5'h0, "R5 clear all flags");
        drive(0, 2'd0, 2'd0, 32'h0, 5'h05, "R7 idle raise");
        drive(0, 2'd0, 2'd0, 32'h0, 5'h00, "R7 idle");
        chk_state("R7 raise ORed mode kept", 8'hC5);
        drive(1, 2'd1, 2'd0, 32'h02, 5'h18, "R8 swap flags with raise");
        chk_state("R8 swap wins", 8'hC2);
        drive(1, 2'd1, 2'd2, 32'h02, 5'h03, "R8 clear bit1 raise bits1,0");
        chk_state("R8 clear wins raise elsewhere", 8'hC1);
        drive(1, 2'd2, 2'd0, 32'hFFFF_FFFD, 5'h10, "R4 R7 swap mode truncated with raise");
        chk_state("R4 R7 mode 5 flags 0x11", 8'hB1);
        drive(1, 2'd3, 2'd0, 32'hFF, 5'h0, "R10 unused view swap");
        drive(1, 2'd0, 2'd3, 32'hFF, 5'h0, "R10 read word unchanged");
        chk_state("R10 nothing changed", 8'hB1);
        drive(1, 2'd1, 2'd1, 32'hFFFF_FFE0, 5'h0, "R6 set flags only above field");
        chk_state("R6 no effect outside view", 8'hB1);
        drive(0, 2'd0, 2'd0, 32'h0, 5'h0, "idle");
        drive(0, 2'd0, 2'd0, 32'h0, 5'h0, "idle");
        chk("R9 queue drained", exp_q.size(), 0);
        chk("R9 valid low when idle", {31'h0, rsp_valid}, '0);
        done = 1'b1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule